// File: doc/BRIEF.md
# Fixed-Point Reciprocal and Inverse Square Root Unit

This scalar unit returns either the reciprocal or the inverse square root of a signed fixed-point operand. It first takes the operand's magnitude. A leading-zero count then normalises that magnitude. Nine bits below the leading one address a 512-entry mantissa ROM. The ROM word is shifted back by an amount that depends on the leading-zero count, and the sign is put back with an XOR mask. Two ROMs exist, one per function. Both are filled at elaboration by constant functions.

Operands are 16 or 32 bits wide, but the data port is 16 bits. A 32-bit operation therefore runs as two steps. First a "high" step latches the upper half of the operand. A following "low" step supplies the lower half and computes the result. Each computing step keeps the upper 16 bits of its 32-bit result. The next "high" step returns them. A "single" step treats its input as a sign-extended 16-bit value, whatever is latched. Every accepted step produces one 16-bit result on the next clock.

Top module: `recip_rsqrt_unit`

## Requirements
- R1: `res_vld_o` is high in exactly the cycle after each cycle in which `vld_i` is high, and low otherwise.
- R2: `op_i` is decoded as 2'b00 single, 2'b01 low, 2'b10 high, and 2'b11 acts as single. A single step uses `din_i` sign-extended to 32 bits. A low step uses {latched high half, `din_i`} when a high half is pending. A low step with nothing pending behaves like a single step.
- R3: The magnitude is the operand XORed with its sign mask, plus one only when the operand is greater than -32768. For more negative operands the one's-complement value is kept, so 0x80000000 yields magnitude 0x7FFFFFFF.
- R4: A zero magnitude gives the 32-bit result 0x7FFFFFFF, whichever function is selected.
- R5: The operand 0xFFFF8000 gives the 32-bit result 0xFFFF0000, whichever function is selected.
- R6: With `fn_i`=0 (reciprocal), the ROM is addressed by bits 30:22 of the normalised magnitude. The result is ({1, entry} << 14) shifted right by (31 − lzc), then XORed with the sign mask. Entry 0 is 0xFFFF. Entry i is the low 16 bits of ((2^34 / (i+512)) + 1) >> 8.
- R7: With `fn_i`=1 (inverse square root), the ROM address is the reciprocal index with its bit 0 replaced by bit 0 of lzc. The shift is (31 − lzc) >> 1. Entry i is the low 16 bits of b >> 1. Here b is the largest value, at least 2^17, with a·b² < 2^44, where a = (i+512), halved when i is odd.
- R8: A single or low step outputs bits 15:0 of the 32-bit result. It stores bits 31:16 for later readback and clears the pending flag.
- R9: A high step sets the pending flag, latches `din_i` as the upper operand half, and outputs the stored upper result half.
- R10: Reset clears the pending flag, the latched high half and the stored result half. A high step right after reset therefore returns 0.
- R11: Cycles with `vld_i` low change no state. `din_i`, `op_i` and `fn_i` are ignored in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vld_i | input | 1 | Step strobe |
| op_i | input | 2 | Step kind: single, low, high |
| fn_i | input | 1 | 0 reciprocal, 1 inverse square root |
| din_i | input | 16 | Operand half |
| res_vld_o | output | 1 | Result valid, one cycle after vld_i |
| res_o | output | 16 | Result half |

## Verification
Two things can coincide in the same cycle. A low step consumes the latched high half while it also stores a new upper result half and clears the pending flag. A high step returns the stored half while it overwrites the latched operand half. The bench provokes both with back-to-back high→low→high sequences, with repeated highs, and with idle gaps carrying garbage inputs. It judges every returned half against a bench model whose state advances only on accepted steps. Directed 32-bit pairs hit the zero, 0xFFFF8000 and 0x80000000 corners through the two-step path.

// File: rtl/recip_rsqrt_unit.sv
module recip_rsqrt_unit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [1:0]    op_i,
  input  logic          fn_i,
  input  logic [DW-1:0] din_i,
  output logic          res_vld_o,
  output logic [DW-1:0] res_o
);
  localparam int OW = 2 * DW;
  localparam int IW = 9;
  localparam int ROM_N = 1 << IW;
  localparam logic [1:0] OP_LOW  = 2'b01;
  localparam logic [1:0] OP_HIGH = 2'b10;

  function automatic logic [15:0] rcp_entry(input int i);
    longint q;
    if (i == 0) return 16'hFFFF;
    q = ((64'sd1 <<< 34) / longint'(i + ROM_N) + 1) >>> 8;
    return 16'(q);
  endfunction

  function automatic logic [15:0] rsq_entry(input int i);
    longint a, lim, b, t;
    a = longint'(i + ROM_N) >>> (i % 2);
    lim = ((64'sd1 <<< 44) - 1) / a;
    b = 0;
    for (int k = 18; k >= 0; k--) begin
      t = b | (64'sd1 <<< k);
      if (t * t <= lim) b = t;
    end
    if (b < (64'sd1 <<< 17)) b = 64'sd1 <<< 17;
    return 16'(b >>> 1);
  endfunction

  function automatic logic [4:0] lzc(input logic [OW-1:0] v);
    logic [4:0] n;
    n = '0;
    for (int k = 0; k < OW; k++)
      if (v[k]) n = 5'(OW - 1 - k);
    return n;
  endfunction

  logic [15:0] rcp_rom [ROM_N];
  logic [15:0] rsq_rom [ROM_N];

  for (genvar g = 0; g < ROM_N; g++) begin : g_rom
    assign rcp_rom[g] = rcp_entry(g);
    assign rsq_rom[g] = rsq_entry(g);
  end

  logic          pend_q;
  logic [DW-1:0] hi_q, sv_q;

  logic [OW-1:0] opnd, mask, ones, mag, base, res32;
  logic [4:0]    lz, shr;
  logic [IW-1:0] idx;
  logic [15:0]   ent;
  logic          use_hi;

  assign use_hi = (op_i == OP_LOW) && pend_q;
  assign opnd   = use_hi ? {hi_q, din_i} : {{DW{din_i[DW-1]}}, din_i};
  assign mask   = {OW{opnd[OW-1]}};
  assign ones   = opnd ^ mask;
  assign mag    = ($signed(opnd) > -32'sd32768) ? ones - mask : ones;
  assign lz     = lzc(mag);
  assign idx    = IW'((mag << lz) >> 22);
  assign shr    = 5'd31 - lz;
  assign ent    = fn_i ? rsq_rom[{idx[IW-1:1], lz[0]}] : rcp_rom[idx];
  assign base   = {1'b0, 1'b1, ent, 14'b0};

  always_comb begin
    if (mag == '0)
      res32 = 32'h7FFF_FFFF;
    else if (opnd == 32'hFFFF_8000)
      res32 = 32'hFFFF_0000;
    else if (fn_i)
      res32 = (base >> (shr >> 1)) ^ mask;
    else
      res32 = (base >> shr) ^ mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      hi_q      <= '0;
      sv_q      <= '0;
      res_o     <= '0;
      res_vld_o <= 1'b0;
    end else begin
      res_vld_o <= vld_i;
      if (vld_i) begin
        if (op_i == OP_HIGH) begin
          pend_q <= 1'b1;
          hi_q   <= din_i;
          res_o  <= sv_q;
        end else begin
          pend_q <= 1'b0;
          sv_q   <= res32[OW-1:DW];
          res_o  <= res32[DW-1:0];
        end
      end
    end
  end

  a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> res_vld_o);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !res_vld_o);
  a_r4_zero_single: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && op_i == 2'b00 && din_i == '0) |=> (res_o == 16'hFFFF));
  a_r5_minneg_single: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && op_i == 2'b00 && din_i == 16'h8000) |=> (res_o == 16'h0000));
  a_r8_clear_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && op_i != OP_HIGH) |=> !pend_q);
  a_r9_set_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && op_i == OP_HIGH) |=> (pend_q && hi_q == $past(din_i)));
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ($stable(pend_q) && $stable(hi_q) && $stable(sv_q) && $stable(res_o)));
endmodule

// File: tb/sim_recip_rsqrt_unit.sv
`timescale 1ns/1ps
module sim_recip_rsqrt_unit;
  logic clk = 1'b0, rst_n = 1'b0, vld_i = 1'b0, fn_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic [15:0] din_i = '0;
  logic res_vld_o;
  logic [15:0] res_o;
  int n_run = 0, n_fail = 0;
  logic [15:0] rt [512];
  logic [15:0] st [512];
  bit m_pend = 0;
  logic [15:0] m_hi = '0, m_sv = '0;

  always #10 clk = ~clk;

  recip_rsqrt_unit u0 (.clk(clk), .rst_n(rst_n), .vld_i(vld_i), .op_i(op_i),
    .fn_i(fn_i), .din_i(din_i), .res_vld_o(res_vld_o), .res_o(res_o));

  function automatic logic [31:0] model(logic [31:0] x, bit f);
    logic [31:0] m, mg, nm, b;
    int p;
    logic [8:0] ix;
    m = x[31] ? 32'hFFFF_FFFF : 32'h0;
    mg = x ^ m;
    if ($signed(x) > -32768 && x[31]) mg = mg + 1;
    if (mg == 0) return 32'h7FFF_FFFF;
    if (x == 32'hFFFF_8000) return 32'hFFFF_0000;
    p = 31;
    while (!mg[p]) p--;
    nm = mg << (31 - p);
    ix = nm[30:22];
    if (!f) begin
      b = {15'b0, 1'b1, rt[ix]} << 14;
      return (b >> p) ^ m;
    end
    ix[0] = 1'((31 - p) & 1);
    b = {15'b0, 1'b1, st[ix]} << 14;
    return (b >> (p >> 1)) ^ m;
  endfunction

  task automatic check(string rq, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic step(logic [1:0] op, bit f, logic [15:0] d, string rq);
    logic [31:0] x, r;
    logic [15:0] e;
    op_i = op; fn_i = f; din_i = d; vld_i = 1'b1;
    if (op == 2'b10) begin
      e = m_sv; m_pend = 1; m_hi = d;
    end else begin
      x = (op == 2'b01 && m_pend) ? {m_hi, d} : {{16{d[15]}}, d};
      r = model(x, f);
      e = r[15:0]; m_sv = r[31:16]; m_pend = 0;
    end
    @(negedge clk);
    vld_i = 1'b0;
    check(rq, res_o, e);
    check("R1", {15'b0, res_vld_o}, 16'd1);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      op_i = 2'($urandom); fn_i = 1'($urandom); din_i = 16'($urandom); vld_i = 1'b0;
      @(negedge clk);
      check("R1 R11", {15'b0, res_vld_o}, 16'd0);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    longint a, b;
    void'($urandom(32'd4242));
    for (int i = 0; i < 512; i++) begin
      rt[i] = (i == 0) ? 16'hFFFF : 16'((((64'sd1 <<< 34) / (i + 512)) + 1) >>> 8);
      a = longint'(i + 512) >>> (i % 2);
      b = longint'($sqrt(17592186044416.0 / real'(a)));
      while (a * (b + 1) * (b + 1) < (64'sd1 <<< 44)) b++;
      while (a * b * b >= (64'sd1 <<< 44)) b--;
      if (b < (64'sd1 <<< 17)) b = 64'sd1 <<< 17;
      st[i] = 16'(b >>> 1);
    end
    repeat (3) @(negedge clk);
    check("R10 reset res", res_o, 16'h0);
    check("R10 reset vld", {15'b0, res_vld_o}, 16'd0);
    rst_n = 1'b1;
    step(2'b10, 0, 16'h1234, "R10 high after reset");
    step(2'b00, 0, 16'h0000, "R4 zero rcp");
    step(2'b10, 0, 16'h0000, "R9 saved 7FFF");
    step(2'b00, 1, 16'h0000, "R4 zero rsq");
    step(2'b00, 0, 16'h8000, "R5 single 8000");
    step(2'b10, 0, 16'hFFFF, "R9 saved FFFF");
    step(2'b01, 1, 16'h8000, "R5 low pair FFFF8000");
    step(2'b10, 0, 16'h8000, "R9 readback");
    step(2'b01, 0, 16'h0000, "R3 pair 80000000");
    step(2'b10, 0, 16'h0000, "R3 upper");
    step(2'b01, 0, 16'h0000, "R4 pair zero");
    step(2'b01, 0, 16'h0001, "R2 low no pending");
    step(2'b00, 0, 16'hFFFF, "R6 minus one");
    step(2'b00, 1, 16'h0001, "R7 one");
    step(2'b00, 1, 16'h0002, "R7 even lz");
    step(2'b11, 0, 16'h0100, "R2 op3 single");
    step(2'b10, 0, 16'h0040, "R9 hi");
    idle(4);
    step(2'b01, 1, 16'h5555, "R11 R2 latch held");
    step(2'b10, 0, 16'h7FFF, "R9 hi");
    step(2'b00, 0, 16'h0003, "R2 single ignores pending");
    step(2'b10, 1, 16'h0000, "R8 upper saved");
    for (int k = 0; k < 3000; k++) begin
      logic [1:0] op;
      op = 2'($urandom);
      step(op, 1'($urandom), 16'($urandom), op == 2'b10 ? "R9 random" :
           ($urandom & 1) ? "R6 R7 R8 random" : "R2 R8 random");
      if ((k % 97) == 0) idle(2);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule